// File: doc/BRIEF.md
# I2C Channel-Select Register Slave

This block is an I2C slave that holds one control byte used to steer a two-way bus multiplexer and to report the state of two downstream interrupt lines. SCL and SDA are sampled on the system clock after a synchroniser chain, and SDA is driven only low, through an open-drain enable. The block answers a 7-bit address that combines a fixed `1110` prefix with three strap inputs.

A write transfer stores the channel-select field of each received byte. The new selection becomes active only once that byte has been acknowledged. A read transfer returns the control byte, which combines the stored select field with the live status of the two active-low interrupt inputs. The outputs are one enable per downstream channel and a combined interrupt flag.

Top module: `i2c_chsel_slave`

## Requirements
- R1: After a synchronous active-low reset, both channel enables are 0 and SDA is released (`sda_oe_o` = 0).
- R2: After START, when the first seven received bits equal `1110` followed by `strap_i[2]`, `strap_i[1]`, `strap_i[0]` (MSB first), the slave holds SDA low for the whole high period of the ninth clock. The eighth bit selects the direction: 0 is write and 1 is read.
- R3: When the address does not match, the slave never drives SDA and changes no state visible at its ports until the next START.
- R4: A written byte stores only bits [2:0] (enable, spare, channel). Bits [7:3], including the interrupt positions, have no effect.
- R5: On a write, the channel enables keep their old value throughout the acknowledge clock of the data byte. The new value appears only after the falling SCL edge that ends that clock.
- R6: Bit 2 of the stored field enables switching. When it is 1, bit 0 selects channel 1 (`ch_en_o` = 2'b10) or channel 0 (2'b01). When it is 0, `ch_en_o` = 2'b00.
- R7: A read returns, MSB first, the byte {0, 0, INT1, INT0, 0, stored bits [2:0]}. INTn reads 1 when `irq_n_i[n]` is low.
- R8: During a read, a master acknowledge causes the next byte to be sent. After a master not-acknowledge, SDA stays released until the next START or STOP.
- R9: Any number of data bytes may follow a write address. Each byte is acknowledged, and each one replaces the stored field.
- R10: A START that arrives in the middle of a byte aborts the transfer. The partial byte is not stored, and a new address phase begins.
- R11: `irq_o` is 1 whenever either `irq_n_i` bit is low.
- R12: A STOP returns the slave to idle and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_i | input | 3 | Low three address bits from board straps |
| irq_n_i | input | 2 | Active-low interrupt inputs of channel 1 and channel 0 |
| ch_en_o | output | 2 | Per-channel enable: bit 1 = channel 1, bit 0 = channel 0 |
| irq_o | output | 1 | Combined interrupt flag, active high |

## Verification
The bench instantiates the block with a three-stage synchroniser, one stage deeper than the default. Every bus edge therefore reaches the state machine with an extra cycle of delay, which tests that each bench phase of eight clocks leaves enough margin for ACK timing and for the moment the channel enable changes. The strap inputs are changed between transfers, so the matching and non-matching branches of the address comparison are both exercised against many address values. Read checks sample the interrupt inputs only after they have settled through the deeper chain.

// File: rtl/chsel_pkg.sv
// Shared definitions for the I2C channel-select slave.
// Assumes a fixed byte size of eight bits and exactly two downstream channels.
package chsel_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned CH_N   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } slv_state_t;
endpackage

// File: rtl/chsel_sync.sv
// Multi-stage synchroniser for asynchronous level inputs.
// Assumes STAGES >= 1; every bit resets to RST_VAL (bus idle level).
module chsel_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/chsel_busmon.sv
// Detects START, STOP and SCL edges from synchronised bus lines.
// Assumes scl_s and sda_s are already synchronised to clk.
module chsel_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic scl_p, sda_p;

    // Keep the previous sample of both lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign start_o    = scl_p & scl_s & sda_p & ~sda_s;
    assign stop_o     = scl_p & scl_s & ~sda_p & sda_s;
    assign scl_rise_o = ~scl_p & scl_s;
    assign scl_fall_o = scl_p & ~scl_s;
endmodule

// File: rtl/chsel_engine.sv
// Bit-level slave engine: address match, write reception, read transmission
// and acknowledge handling. SDA is only ever pulled low through sda_oe_o.
// Assumes PREFIX_W + STRAP_W == 7 and that bus events come from chsel_busmon.
module chsel_engine
    import chsel_pkg::*;
#(
    parameter int unsigned       PREFIX_W = 4,
    parameter logic [PREFIX_W-1:0] PREFIX = 4'b1110,
    parameter int unsigned       STRAP_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [BYTE_W-1:0]  status_i,
    output logic               sda_oe_o,
    output logic               wr_stb_o,
    output logic [BYTE_W-1:0]  wr_byte_o
);
    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    slv_state_t        state_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] tx_q;
    logic              rw_q;
    logic              sda_oe_q;
    logic              mack_q;
    logic              addr_hit;

    assign addr_hit = (sh_q[BYTE_W-1:1] == {PREFIX, strap_i});

    // Main bus state machine; START and STOP override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            sh_q     <= '0;
            tx_q     <= '0;
            rw_q     <= 1'b0;
            sda_oe_q <= 1'b0;
            mack_q   <= 1'b0;
        end else if (start_i) begin
            state_q  <= ST_ADDR;
            bitcnt_q <= '0;
            sda_oe_q <= 1'b0;
        end else if (stop_i) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            sda_oe_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        sh_q     <= {sh_q[BYTE_W-2:0], sda_i};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end else if (scl_fall_i && bitcnt_q == LAST_BIT) begin
                        bitcnt_q <= '0;
                        if (addr_hit) begin
                            state_q  <= ST_ADDR_ACK;
                            rw_q     <= sh_q[0];
                            sda_oe_q <= 1'b1;
                        end else begin
                            state_q <= ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        if (rw_q) begin
                            state_q  <= ST_RD_DATA;
                            tx_q     <= status_i;
                            sda_oe_q <= ~status_i[BYTE_W-1];
                        end else begin
                            state_q  <= ST_WR_DATA;
                            sda_oe_q <= 1'b0;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (scl_rise_i) begin
                        sh_q     <= {sh_q[BYTE_W-2:0], sda_i};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end else if (scl_fall_i && bitcnt_q == LAST_BIT) begin
                        bitcnt_q <= '0;
                        state_q  <= ST_WR_ACK;
                        sda_oe_q <= 1'b1;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall_i) begin
                        state_q  <= ST_WR_DATA;
                        sda_oe_q <= 1'b0;
                    end
                end
                ST_RD_DATA: begin
                    if (scl_rise_i) begin
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end else if (scl_fall_i) begin
                        if (bitcnt_q == LAST_BIT) begin
                            bitcnt_q <= '0;
                            state_q  <= ST_RD_ACK;
                            sda_oe_q <= 1'b0;
                        end else begin
                            sda_oe_q <= ~tx_q[3'd7 - bitcnt_q[2:0]];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise_i) begin
                        mack_q <= ~sda_i;
                    end else if (scl_fall_i) begin
                        if (mack_q) begin
                            state_q  <= ST_RD_DATA;
                            tx_q     <= status_i;
                            sda_oe_q <= ~status_i[BYTE_W-1];
                        end else begin
                            state_q <= ST_IGNORE;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign sda_oe_o  = sda_oe_q;
    assign wr_stb_o  = (state_q == ST_WR_ACK) && scl_fall_i && !start_i && !stop_i;
    assign wr_byte_o = sh_q;

    // R3
    ignore_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !sda_oe_o);

    // R12
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (state_q == ST_IDLE) && !sda_oe_o);

    // R10
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == ST_ADDR) && (bitcnt_q == '0));

    // R2
    ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK || state_q == ST_WR_ACK) |-> sda_oe_o);
endmodule

// File: rtl/chsel_ctrl.sv
// Control register: holds the select field, decodes channel enables and
// assembles the readable byte with live interrupt status.
// Assumes irq_n_s is synchronised and active low; wr_stb_i is a one-cycle pulse.
module chsel_ctrl
    import chsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [CH_N-1:0]   irq_n_s,
    output logic [CH_N-1:0]   ch_en_o,
    output logic              irq_o,
    output logic [BYTE_W-1:0] status_o
);
    logic [SEL_W-1:0] sel_q;

    // Capture the writable field when the engine commits a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_stb_i) begin
            sel_q <= wr_sel_i;
        end
    end

    genvar g;
    generate
        for (g = 0; g < CH_N; g++) begin : g_chan
            assign ch_en_o[g] = sel_q[2] & (sel_q[0] == 1'(g));
        end
    endgenerate

    assign irq_o    = ~&irq_n_s;
    assign status_o = {2'b00, ~irq_n_s[1], ~irq_n_s[0], 1'b0, sel_q};

    // R6
    chan_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_en_o));

    // R4
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_i |=> $stable(sel_q));
endmodule

// File: rtl/i2c_chsel_slave.sv
// Top level of the I2C channel-select slave: synchronisers, bus event
// detection, the slave engine and the control register.
// Assumes SCL/SDA are asynchronous and SDA is resolved externally as wired-AND.
module i2c_chsel_slave
    import chsel_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PREFIX_W    = 4,
    parameter logic [PREFIX_W-1:0] PREFIX = 4'b1110,
    parameter int unsigned STRAP_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [1:0]         irq_n_i,
    output logic [1:0]         ch_en_o,
    output logic               irq_o
);
    logic              scl_s, sda_s;
    logic [CH_N-1:0]   irq_s;
    logic              start, stop, scl_rise, scl_fall;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] status;

    chsel_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
    );

    chsel_sync #(.W(CH_N), .STAGES(SYNC_STAGES), .RST_VAL({CH_N{1'b1}})) u_irq_sync (
        .clk(clk), .rst_n(rst_n), .d_i(irq_n_i), .q_o(irq_s)
    );

    chsel_busmon u_busmon (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .start_o(start), .stop_o(stop), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
    );

    chsel_engine #(.PREFIX_W(PREFIX_W), .PREFIX(PREFIX), .STRAP_W(STRAP_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
        .strap_i(strap_i), .status_i(status), .sda_oe_o(sda_oe_o),
        .wr_stb_o(wr_stb), .wr_byte_o(wr_byte)
    );

    chsel_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .wr_sel_i(wr_byte[SEL_W-1:0]),
        .irq_n_s(irq_s), .ch_en_o(ch_en_o), .irq_o(irq_o), .status_o(status)
    );

    // R11
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_s[0]) |-> irq_o);
endmodule

// File: tb/tb_i2c_chsel_slave.sv
`timescale 1ns/1ps
module tb_i2c_chsel_slave;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [2:0] strap = 3'b000;
    logic [1:0] irq_n = 2'b11;
    logic [1:0] ch_en;
    logic       irq;
    logic       watch = 1'b0;
    logic       pulled = 1'b0;
    logic       done = 1'b0;
    int n_chk = 0;
    int n_fail = 0;
    logic [2:0] model = 3'b000;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_chsel_slave #(.SYNC_STAGES(3)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .strap_i(strap), .irq_n_i(irq_n), .ch_en_o(ch_en), .irq_o(irq)
    );

    always @(posedge clk) if (watch && sda_oe) pulled = 1'b1;

    function automatic logic [1:0] ch_of(input logic [2:0] s);
        return s[2] ? (s[0] ? 2'b10 : 2'b01) : 2'b00;
    endfunction

    function automatic logic [7:0] stat_of(input logic [2:0] s, input logic [1:0] n);
        return {2'b00, ~n[1], ~n[0], 1'b0, s};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b, output logic seen);
        sda_m = b; tick(Q);
        scl = 1'b1; tick(Q);
        seen = sda_line; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rw, output logic ackd);
        logic s;
        for (int i = 6; i >= 0; i--) send_bit(a[i], s);
        send_bit(rw, s);
        send_bit(1'b1, s);
        ackd = ~s;
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ackd,
                           output logic [1:0] en_mid, output logic [1:0] en_after);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(d[i], s);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        ackd = ~sda_line;
        en_mid = ch_en; tick(Q);
        scl = 1'b0; tick(Q);
        en_after = ch_en;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d, output logic ack_line);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, s);
            d[i] = s;
        end
        send_bit(~mack, s);
        ack_line = s;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic ack, al;
        logic [1:0] em, ea;
        logic [7:0] d;
        logic [6:0] a;
        void'($urandom(32'h5eed_1234));
        tick(5);
        rst_n = 1'b1;
        tick(Q);
        // R1: reset state
        check("R1 ch_en", {6'b0, ch_en}, 8'h00);
        check("R1 sda_oe", {7'b0, sda_oe}, 8'h00);
        check("R11 idle irq", {7'b0, irq}, 8'h00);

        // R2 R4 R5 R6: write with interrupt and spare bits set
        strap = 3'b101;
        tick(Q);
        do_start();
        send_addr({4'b1110, strap}, 1'b0, ack);
        check("R2 addr ack", {7'b0, ack}, 8'h01);
        wr_byte(8'hFD, ack, em, ea);
        model = 3'b101;
        check("R9 data ack", {7'b0, ack}, 8'h01);
        check("R5 old channel during ack", {6'b0, em}, 8'h00);
        check("R6 channel 1 selected", {6'b0, ea}, {6'b0, ch_of(model)});
        do_stop();
        check("R12 released after stop", {7'b0, sda_oe}, 8'h00);

        // R7 R8 R11: read with channel 0 interrupt pending
        irq_n = 2'b10;
        tick(Q);
        check("R11 irq flag", {7'b0, irq}, 8'h01);
        do_start();
        send_addr({4'b1110, strap}, 1'b1, ack);
        check("R2 read ack", {7'b0, ack}, 8'h01);
        rd_byte(1'b1, d, al);
        check("R7 read byte", d, stat_of(model, irq_n));
        rd_byte(1'b0, d, al);
        check("R8 second byte", d, stat_of(model, irq_n));
        check("R8 released after nack", {7'b0, al}, 8'h01);
        watch = 1'b1; pulled = 1'b0;
        send_bit(1'b1, al);
        watch = 1'b0;
        check("R8 silent after nack", {7'b0, pulled}, 8'h00);
        do_stop();

        // R9 R6: several bytes in one write
        do_start();
        send_addr({4'b1110, strap}, 1'b0, ack);
        wr_byte(8'h04, ack, em, ea); model = 3'b100;
        check("R9 byte1", {6'b0, ea}, {6'b0, ch_of(model)});
        wr_byte(8'h00, ack, em, ea); model = 3'b000;
        check("R9 byte2 none", {6'b0, ea}, 8'h00);
        wr_byte(8'h06, ack, em, ea); model = 3'b110;
        check("R9 byte3 ack", {7'b0, ack}, 8'h01);
        check("R6 channel 0", {6'b0, ea}, 8'h01);
        do_stop();

        // R3: mismatching address is ignored
        do_start();
        watch = 1'b1; pulled = 1'b0;
        send_addr({4'b1110, strap ^ 3'b010}, 1'b0, ack);
        wr_byte(8'h05, ack, em, ea);
        watch = 1'b0;
        check("R3 no ack", {7'b0, pulled}, 8'h00);
        check("R3 channel unchanged", {6'b0, ea}, {6'b0, ch_of(model)});
        do_stop();

        // R10: START mid-byte aborts the write
        do_start();
        send_addr({4'b1110, strap}, 1'b0, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b1, al);
        do_start();
        check("R10 partial not stored", {6'b0, ch_en}, {6'b0, ch_of(model)});
        send_addr({4'b1110, strap}, 1'b1, ack);
        check("R10 readdress ack", {7'b0, ack}, 8'h01);
        rd_byte(1'b0, d, al);
        check("R10 field intact", d, stat_of(model, irq_n));
        do_stop();

        // R12: STOP right after address
        do_start();
        send_addr({4'b1110, strap}, 1'b0, ack);
        do_stop();
        check("R12 idle after stop", {5'b0, sda_oe, ch_en}, {5'b0, 1'b0, ch_of(model)});

        // Random transfers
        for (int t = 0; t < 30; t++) begin
            logic hit, rw;
            int nb;
            strap = 3'($urandom);
            irq_n = 2'($urandom);
            tick(Q);
            hit = ($urandom % 4) != 0;
            a = hit ? {4'b1110, strap} : {4'b1110, strap ^ 3'(1 + $urandom % 7)};
            rw = 1'($urandom);
            nb = 1 + int'($urandom % 3);
            do_start();
            watch = ~hit; pulled = 1'b0;
            send_addr(a, rw, ack);
            check(hit ? "R2 random ack" : "R3 random nack", {7'b0, ack}, {7'b0, hit});
            for (int b = 0; b < nb; b++) begin
                if (!rw) begin
                    d = 8'($urandom);
                    wr_byte(d, ack, em, ea);
                    check("R5 random hold", {6'b0, em}, {6'b0, ch_of(model)});
                    if (hit) model = d[2:0];
                    check("R4 random commit", {6'b0, ea}, {6'b0, ch_of(model)});
                end else begin
                    rd_byte(b != nb - 1, d, al);
                    if (hit) check("R7 random read", d, stat_of(model, irq_n));
                end
            end
            watch = 1'b0;
            if (!hit) check("R3 random silent", {7'b0, pulled}, 8'h00);
            check("R11 random irq", {7'b0, irq}, {7'b0, ~&irq_n});
            do_stop();
            check("R12 random release", {7'b0, sda_oe}, 8'h00);
        end

        done = 1'b1;
        finish_run();
    end
endmodule